// File: doc/BRIEF.md
# Reference Clock Loss-of-Signal Monitor

This block watches one reference clock for missing edges, using a free-running monitor clock as its timebase. The reference is brought into the monitor domain and its rising edges are detected there. A timer counts monitor cycles since the last detected edge and restarts on every edge. When the timer reaches a programmable limit, a first-stage alarm raises a freeze flag that tells the tracking loop to stop adjusting. A second limit expiry in a row, with still no edge, declares loss of signal.

Loss of signal is sticky. It only clears after eight rising reference edges are seen. If a full timer period passes without an edge while those edges are being counted, the count starts again from zero. This lets a gapped reference with a known, bounded gap pass without false alarms: the limit is set just above the longest expected gap. A limit of zero turns the monitor off. An interrupt pulse marks every change of either flag, and each flag has its own mask bit.

Top module: `clk_los_monitor`

## Requirements
- R1: A rising reference edge restarts the timer. A reference whose rising edges are closer together than the limit `tc_cfg` (in monitor cycles) never raises either flag.
- R2: When `tc_cfg` monitor cycles pass with no rising edge, `freeze_o` goes high and `los_o` stays low.
- R3: A rising edge that arrives while `freeze_o` is high and before the second expiry clears `freeze_o`, and `los_o` never rises.
- R4: A second consecutive expiry with no edge sets `los_o`. `freeze_o` stays high whenever `los_o` is high, and `los_o` only rises out of the frozen state.
- R5: After `los_o` is set, it stays high through seven rising edges and clears on the eighth. `freeze_o` clears with it.
- R6: During that qualification, a full timer period with no edge resets the edge count to zero. Eight fresh edges are then needed.
- R7: `tc_cfg` = 0 disables the monitor. Both flags clear one cycle later and stay low whatever the reference does.
- R8: `irq_o` is high for exactly the first cycle in which a changed `{los_o, freeze_o}` value is visible, if any changed bit is unmasked. `irq_mask` bit 0 masks `freeze_o` changes and bit 1 masks `los_o` changes. `irq_o` is never high otherwise.
- R9: After reset, `freeze_o`, `los_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_mon |
| ref_clk | input | 1 | Reference clock under watch (asynchronous) |
| tc_cfg | input | CNT_W (17) | Timeout limit in monitor cycles; 0 disables |
| irq_mask | input | 2 | Bit 0 masks freeze changes, bit 1 masks loss changes |
| freeze_o | output | 1 | First-stage alarm: loop must not adjust |
| los_o | output | 1 | Loss of signal |
| irq_o | output | 1 | One-cycle pulse on an unmasked flag change |

## Verification
The properties assume the reference is slower than half the monitor clock, so that no edge is lost in the synchronizer. The bench drives a reference period of ten monitor cycles to stay within that. The timer-bound property holds only in cycles where the limit equals its value of the previous cycle, and the bench changes the limit only while the reference is idle. Gaps are chosen well clear of the expiry points, so the result never depends on the exact synchronizer latency.

// File: rtl/clk_los_monitor.sv
module clk_los_monitor #(
  parameter int CNT_W       = 17,
  parameter int QUAL_EDGES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_mon,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic [CNT_W-1:0] tc_cfg,
  input  logic [1:0]       irq_mask,
  output logic             freeze_o,
  output logic             los_o,
  output logic             irq_o
);
  localparam int QW = $clog2(QUAL_EDGES + 1);

  typedef enum logic [1:0] {ST_OK, ST_SOFT, ST_LOS} st_t;

  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]     cnt;
  logic [QW-1:0]        qual;
  logic [1:0]           stat_q;
  st_t                  st;

  wire rise      = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  wire enabled   = |tc_cfg;
  wire expire    = enabled & ~rise & (cnt >= tc_cfg - CNT_W'(1));
  wire qual_done = (qual == QW'(QUAL_EDGES - 1));

  assign los_o    = (st == ST_LOS);
  assign freeze_o = (st != ST_OK);
  assign irq_o    = |(({los_o, freeze_o} ^ stat_q) & ~irq_mask);

  always_ff @(posedge clk_mon) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt    <= '0;
      qual   <= '0;
      st     <= ST_OK;
      stat_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], ref_clk};
      stat_q <= {los_o, freeze_o};
      if (!enabled) begin
        cnt  <= '0;
        qual <= '0;
        st   <= ST_OK;
      end else begin
        cnt <= (rise || expire) ? '0 : cnt + CNT_W'(1);
        case (st)
          ST_OK:   if (expire) st <= ST_SOFT;
          ST_SOFT: begin
            if (rise) st <= ST_OK;
            else if (expire) begin
              st   <= ST_LOS;
              qual <= '0;
            end
          end
          ST_LOS: begin
            if (rise) begin
              if (qual_done) begin
                st   <= ST_OK;
                qual <= '0;
              end else qual <= qual + QW'(1);
            end else if (expire) qual <= '0;
          end
          default: st <= ST_OK;
        endcase
      end
    end
  end
endmodule

module clk_los_monitor_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk_mon,
  input logic             rst_n,
  input logic [CNT_W-1:0] tc_cfg,
  input logic [1:0]       irq_mask,
  input logic             freeze_o,
  input logic             los_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt
);
  p_cnt_bound_r1: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (tc_cfg != 0 && tc_cfg == $past(tc_cfg)) |-> cnt < tc_cfg);
  p_soft_first_r2: assert property (@(posedge clk_mon) disable iff (!rst_n)
    $rose(freeze_o) |-> !los_o);
  p_los_freezes_r4: assert property (@(posedge clk_mon) disable iff (!rst_n)
    los_o |-> freeze_o);
  p_los_after_soft_r4: assert property (@(posedge clk_mon) disable iff (!rst_n)
    $rose(los_o) |-> $past(freeze_o));
  p_disabled_clear_r7: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (tc_cfg == 0) |=> (!los_o && !freeze_o));
  p_masked_quiet_r8: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (&irq_mask) |-> !irq_o);
  p_change_pulses_r8: assert property (@(posedge clk_mon) disable iff (!rst_n)
    (irq_mask == 2'b00 && !$stable({los_o, freeze_o})) |-> irq_o);
endmodule

bind clk_los_monitor clk_los_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_mon(clk_mon), .rst_n(rst_n), .tc_cfg(tc_cfg), .irq_mask(irq_mask),
  .freeze_o(freeze_o), .los_o(los_o), .irq_o(irq_o), .cnt(cnt)
);

// File: tb/clk_los_monitor_tb_top.sv
module clk_los_monitor_tb_top;
  logic        clk_mon = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic [16:0] tc_cfg = 17'd20;
  logic [1:0]  irq_mask = 2'b00;
  logic        freeze_o, los_o, irq_o;
  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q[$];
  logic [1:0] last_st = 2'b00;
  bit monitor_on = 1'b0;

  always #2 clk_mon = ~clk_mon;

  clk_los_monitor dut_i (
    .clk_mon(clk_mon), .rst_n(rst_n), .ref_clk(ref_clk), .tc_cfg(tc_cfg),
    .irq_mask(irq_mask), .freeze_o(freeze_o), .los_o(los_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_mon);
    #1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1; wait_cyc(5);
      ref_clk = 1'b0; wait_cyc(5);
    end
  endtask

  task automatic expect_st(input logic [1:0] v);
    exp_q.push_back(v);
  endtask

  // scoreboard monitor: status is {los_o, freeze_o}
  always @(negedge clk_mon) begin
    if (monitor_on) begin
      logic [1:0] st;
      st = {los_o, freeze_o};
      if (st != last_st) begin
        if (exp_q.size() == 0)
          check(1'b0, "R8 unexpected status change", st, last_st);
        else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          check(st == e, "R4 status sequence", st, e);
        end
        check(irq_o == |((st ^ last_st) & ~irq_mask), "R8 irq on change",
              irq_o, |((st ^ last_st) & ~irq_mask));
      end else if (irq_o) begin
        check(1'b0, "R8 irq without change", 1, 0);
      end
      last_st = st;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_mon);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    @(negedge clk_mon);
    check(!los_o && !freeze_o && !irq_o, "R9 reset state", {los_o, freeze_o, irq_o}, 0);
    monitor_on = 1'b1;
    wait_cyc(1);

    pulses(20);
    check(!freeze_o && !los_o, "R1 steady reference", {los_o, freeze_o}, 0);

    expect_st(2'b01); expect_st(2'b11);
    wait_cyc(30);
    check(freeze_o && !los_o, "R2 first expiry", {los_o, freeze_o}, 1);
    wait_cyc(20);
    check(los_o && freeze_o, "R4 second expiry", {los_o, freeze_o}, 3);

    expect_st(2'b00);
    pulses(7);
    check(los_o, "R5 seven edges keep loss", los_o, 1);
    pulses(1);
    check(!los_o && !freeze_o, "R5 eighth edge clears", {los_o, freeze_o}, 0);

    expect_st(2'b01); expect_st(2'b00);
    wait_cyc(25);
    check(freeze_o && !los_o, "R2 freeze in gap", {los_o, freeze_o}, 1);
    pulses(3);
    check(!freeze_o && !los_o, "R3 edge releases freeze", {los_o, freeze_o}, 0);

    irq_mask = 2'b11;
    expect_st(2'b01); expect_st(2'b11);
    wait_cyc(50);
    check(los_o, "R4 loss while masked", los_o, 1);
    pulses(5);
    wait_cyc(30);
    expect_st(2'b00);
    pulses(7);
    check(los_o, "R6 qualification restarted", los_o, 1);
    pulses(1);
    check(!los_o, "R6 clears after fresh eight", los_o, 0);

    irq_mask = 2'b01;
    tc_cfg = 17'd0;
    wait_cyc(100);
    check(!freeze_o && !los_o, "R7 disabled no alarm", {los_o, freeze_o}, 0);
    expect_st(2'b01); expect_st(2'b11);
    tc_cfg = 17'd20;
    wait_cyc(50);
    check(los_o, "R4 loss after enable", los_o, 1);
    expect_st(2'b00);
    tc_cfg = 17'd0;
    wait_cyc(2);
    check(!los_o && !freeze_o, "R7 disable clears alarms", {los_o, freeze_o}, 0);
    irq_mask = 2'b00;
    tc_cfg = 17'd20;
    pulses(3);
    check(!los_o && !freeze_o, "R1 reenabled steady", {los_o, freeze_o}, 0);

    wait_cyc(2);
    check(exp_q.size() == 0, "R8 all expected changes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule